// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking in-memory translation tables. A walk starts from a context table entry chosen by a context number and a table pointer, and then goes through up to three levels of tables. It reads one 32-bit word at a time over a simple request/acknowledge memory port. Each entry it reads is decoded as invalid, pointer, leaf or reserved. A pointer entry gives the base of the next table. The virtual address supplies that table's index from a fixed bit slice.

When the walk reaches a leaf at the last level, the block checks the requested access against the entry's 3-bit permission field. If the access is allowed, it sets the entry's referenced flag, and also its modified flag on a write. It writes the entry back only when one of these flags actually changed. The result is either a 36-bit physical address or a 10-bit fault code. The fault code records the level where the walk stopped and the kind of fault. A 3-bit access index describing the request is reported in both cases.

A requester pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads the results, which stay unchanged until the next start.

Top module: `pt_walker`

## Requirements
- R1: A start issues a read at address (ctp << 4) + (ctx << 4), computed modulo 2^32.
- R2: After a pointer entry read at level L (0 to 2), the next read is at ((entry & ~3) << 4) + 4 * idx. The index idx is vaddr[31:24] for level 1, vaddr[23:18] for level 2 and vaddr[17:12] for level 3.
- R3: Entry bits [1:0] give the type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. An invalid entry ends the walk with fault type 1.
- R4: Fault type 4 ends the walk in three cases: a reserved entry at any level, a leaf at levels 0 to 2, and a pointer at level 3.
- R5: `acc_idx` = 4·write + 2·fetch + 1·supervisor. It is latched at start and valid at `done` whether or not the walk faulted.
- R6: A leaf's permission field is bits [4:2]. Codes 0 to 5 grant: 0 read; 1 read/write; 2 read/execute; 3 all three; 4 execute; 5 read for user mode and read/write for supervisor. Codes 6 and 7 give supervisor read/execute and read/write/execute, and give a user access fault type 3. A write needs write permission, a fetch needs execute permission, and any other access needs read permission. A request that lacks what it needs gets fault type 2 at level 3.
- R7: On a permitted leaf access, bit 5 (referenced) is set, and bit 6 (modified) is set for a write. The updated word is written back to the leaf's own address only if it differs from the word read.
- R8: On success, `fault` = 0, `fault_code` = 0 and `paddr` = {entry[31:8], vaddr[11:0]}. On a fault, `paddr` = 0.
- R9: `busy` rises the cycle after an accepted start and stays high until `done` pulses for one cycle. A start while busy is ignored. Results are held until the next start.
- R10: At most one memory request is outstanding. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. No request is made while idle.
- R11: The fault code is level << 8 | type << 2. Level 0 is the context entry and levels 1 to 3 are the tables. All other bits are zero.
- R12: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| ctx | input | CTX_W | Context number |
| ctp | input | 32 | Context table pointer |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made in supervisor mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 10 | Level and fault type |
| acc_idx | output | 3 | Access index of the last walk |
| paddr | output | 36 | Translated physical address |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Some properties are checked on every cycle. These cover the request port staying stable until acknowledged, the absence of requests while idle, the one-cycle done pulse, and results holding while idle. They also cover the shape of every fault code, the fact that permission faults are always tagged with level 3, and the referenced bit being set in every write-back. Other behaviour can only be shown by the bench's scenarios against a modelled memory. This includes the fetch addresses derived from the pointer, context and address slices, and the entry-type decoding at each level. It also includes the permission outcome for each access-index and field pair, and whether a write-back occurs at all.

// File: rtl/pt_walker_pkg.sv
// Shared types and helpers for the page table walker.
// Assumes 32-bit table entries and 4 KiB pages.
package pt_walker_pkg;
    localparam int ENTRY_W  = 32;
    localparam int PAGE_OFS = 12;
    localparam int PPN_W    = ENTRY_W - 8;
    localparam int PA_W     = PPN_W + PAGE_OFS;
    localparam int FC_W     = 10;
    localparam int BIT_REF  = 5;
    localparam int BIT_MOD  = 6;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_PTR     = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WBACK = 2'd2
    } st_e;

    localparam logic [2:0] FT_NONE    = 3'd0;
    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_PROT    = 3'd2;
    localparam logic [2:0] FT_PRIV    = 3'd3;
    localparam logic [2:0] FT_BADTYPE = 3'd4;

    // Pack walk level and fault type into the reported code.
    function automatic logic [FC_W-1:0] mk_code(input logic [1:0] lvl, input logic [2:0] ft);
        return {lvl, 3'b000, ft, 2'b00};
    endfunction
endpackage

// File: rtl/pt_addr_gen.sv
// Fetch address generator.
// In root mode it forms the context entry address from the pointer and the context.
// Otherwise it adds the base held in a pointer entry to the index taken from the
// virtual-address slice of the requested level.
// Assumes CTX_W < 32.
module pt_addr_gen #(
    parameter int CTX_W = 8
) (
    input  logic             root,
    input  logic [1:0]       lvl,
    input  logic [31:0]      entry,
    input  logic [19:0]      va_hi,
    input  logic [31:0]      ctp,
    input  logic [CTX_W-1:0] ctx,
    output logic [31:0]      addr
);
    localparam int PAD = 32 - CTX_W;

    logic [31:0] base;
    logic [31:0] idx;

    // Select the level's index slice and form the address.
    always_comb begin
        base = (entry & ~32'h3) << 4;
        case (lvl)
            2'd1:    idx = {22'd0, va_hi[19:12], 2'b00};
            2'd2:    idx = {24'd0, va_hi[11:6], 2'b00};
            2'd3:    idx = {24'd0, va_hi[5:0], 2'b00};
            default: idx = 32'd0;
        endcase
        if (root)
            addr = (ctp << 4) + ({{PAD{1'b0}}, ctx} << 4);
        else
            addr = base + idx;
    end
endmodule

// File: rtl/pt_perm_check.sv
// Leaf permission check.
// Maps the 3-bit permission field and the access index to a fault type:
// 0 means allowed, 2 means protection, 3 means a user touching a supervisor-only page.
module pt_perm_check
    import pt_walker_pkg::*;
(
    input  logic [2:0] acc_field,
    input  logic [2:0] acc_idx,
    output logic [2:0] ftype
);
    logic wr, fx, sv;
    logic can_r, can_w, can_x;

    // Decode the granted rights and compare them with the request.
    always_comb begin
        wr = acc_idx[2];
        fx = acc_idx[1];
        sv = acc_idx[0];
        can_r = 1'b0;
        can_w = 1'b0;
        can_x = 1'b0;
        case (acc_field)
            3'd0: can_r = 1'b1;
            3'd1: begin can_r = 1'b1; can_w = 1'b1; end
            3'd2: begin can_r = 1'b1; can_x = 1'b1; end
            3'd3: begin can_r = 1'b1; can_w = 1'b1; can_x = 1'b1; end
            3'd4: can_x = 1'b1;
            3'd5: begin can_r = 1'b1; can_w = sv; end
            3'd6: begin can_r = sv; can_x = sv; end
            default: begin can_r = sv; can_w = sv; can_x = sv; end
        endcase
        ftype = FT_NONE;
        if (!sv && (acc_field[2:1] == 2'b11))
            ftype = FT_PRIV;
        else if ((wr && !can_w) || (fx && !can_x) || (!wr && !fx && !can_r))
            ftype = FT_PROT;
    end
endmodule

// File: rtl/pt_walker.sv
// Three-level page table walker.
// It makes one memory access at a time. The request stays valid until mem_ack,
// and read data is taken from mem_rdata in the same cycle as mem_ack.
// Results hold from done until the next accepted start.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      vaddr,
    input  logic [CTX_W-1:0] ctx,
    input  logic [31:0]      ctp,
    input  logic             acc_write,
    input  logic             acc_fetch,
    input  logic             acc_super,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [FC_W-1:0]  fault_code,
    output logic [2:0]       acc_idx,
    output logic [PA_W-1:0]  paddr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata
);
    st_e         state_q;
    logic [1:0]  level_q;
    logic [31:0] addr_q;
    logic [31:0] wdata_q;
    logic [19:0] va_hi_q;
    logic [11:0] va_lo_q;
    logic [2:0]  acc_q;

    logic        idle;
    ent_type_e   etype;
    logic [1:0]  gen_lvl;
    logic [19:0] gen_va;
    logic [31:0] next_addr;
    logic [2:0]  perm_ft;
    logic [31:0] upd_entry;

    assign idle    = (state_q == ST_IDLE);
    assign etype   = ent_type_e'(mem_rdata[1:0]);
    assign gen_lvl = level_q + 2'd1;
    assign gen_va  = idle ? vaddr[31:12] : va_hi_q;

    pt_addr_gen #(.CTX_W(CTX_W)) u_addr (
        .root  (idle),
        .lvl   (gen_lvl),
        .entry (mem_rdata),
        .va_hi (gen_va),
        .ctp   (ctp),
        .ctx   (ctx),
        .addr  (next_addr)
    );

    pt_perm_check u_perm (
        .acc_field (mem_rdata[4:2]),
        .acc_idx   (acc_q),
        .ftype     (perm_ft)
    );

    // Status flag update applied to a permitted leaf.
    always_comb begin
        upd_entry = mem_rdata;
        upd_entry[BIT_REF] = 1'b1;
        if (acc_q[2])
            upd_entry[BIT_MOD] = 1'b1;
    end

    // Memory port and status outputs follow the state.
    assign busy       = !idle;
    assign mem_req    = (state_q == ST_FETCH) || (state_q == ST_WBACK);
    assign mem_we     = (state_q == ST_WBACK);
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign acc_idx    = acc_q;

    // Walk sequencing, entry decode and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            level_q    <= 2'd0;
            addr_q     <= 32'd0;
            wdata_q    <= 32'd0;
            va_hi_q    <= 20'd0;
            va_lo_q    <= 12'd0;
            acc_q      <= 3'd0;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_code <= '0;
            paddr      <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        va_hi_q    <= vaddr[31:12];
                        va_lo_q    <= vaddr[11:0];
                        acc_q      <= {acc_write, acc_fetch, acc_super};
                        addr_q     <= next_addr;
                        level_q    <= 2'd0;
                        fault      <= 1'b0;
                        fault_code <= '0;
                        paddr      <= '0;
                        state_q    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        case (etype)
                            ET_PTR: begin
                                if (level_q == 2'd3) begin
                                    fault      <= 1'b1;
                                    fault_code <= mk_code(level_q, FT_BADTYPE);
                                    done       <= 1'b1;
                                    state_q    <= ST_IDLE;
                                end else begin
                                    addr_q  <= next_addr;
                                    level_q <= gen_lvl;
                                end
                            end
                            ET_LEAF: begin
                                if (level_q != 2'd3) begin
                                    fault      <= 1'b1;
                                    fault_code <= mk_code(level_q, FT_BADTYPE);
                                    done       <= 1'b1;
                                    state_q    <= ST_IDLE;
                                end else if (perm_ft != FT_NONE) begin
                                    fault      <= 1'b1;
                                    fault_code <= mk_code(level_q, perm_ft);
                                    done       <= 1'b1;
                                    state_q    <= ST_IDLE;
                                end else begin
                                    paddr <= {mem_rdata[31:8], va_lo_q};
                                    if (upd_entry != mem_rdata) begin
                                        wdata_q <= upd_entry;
                                        state_q <= ST_WBACK;
                                    end else begin
                                        done    <= 1'b1;
                                        state_q <= ST_IDLE;
                                    end
                                end
                            end
                            ET_RSVD: begin
                                fault      <= 1'b1;
                                fault_code <= mk_code(level_q, FT_BADTYPE);
                                done       <= 1'b1;
                                state_q    <= ST_IDLE;
                            end
                            default: begin
                                fault      <= 1'b1;
                                fault_code <= mk_code(level_q, FT_INVALID);
                                done       <= 1'b1;
                                state_q    <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result checker for pt_walker.
// It observes only the top module's ports and is attached by bind.
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            fault,
    input logic [FC_W-1:0] fault_code,
    input logic [PA_W-1:0] paddr,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [31:0]     mem_addr,
    input logic [31:0]     mem_wdata
);
    // R10: request fields hold until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10: no request while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done only appears once the walker is idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: an accepted start makes the walker busy
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R9: results hold while idle without a start
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fault) && $stable(fault_code) && $stable(paddr)));

    // R11: fault code layout and legal types
    a_r11_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code[1:0] == 2'b00 && fault_code[7:5] == 3'b000 &&
                             fault_code[4:2] != 3'd0 && fault_code[4:2] <= 3'd4));

    // R8: success reports a zero code
    a_r8_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (fault_code == '0));

    // R6: permission faults belong to the last level
    a_r6_perm_level: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && (fault_code[4:2] == 3'd2 || fault_code[4:2] == 3'd3)) |-> (fault_code[9:8] == 2'd3));

    // R7: every write-back carries the referenced flag
    a_r7_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_REF]);
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .paddr      (paddr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start = 1'b0;
    logic [31:0] vaddr = 32'd0;
    logic [7:0]  ctx = 8'd2;
    logic [31:0] ctp = 32'h10;
    logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_super = 1'b0;
    logic        busy, done, fault;
    logic [9:0]  fault_code;
    logic [2:0]  acc_idx;
    logic [35:0] paddr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    pt_walker #(.CTX_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .ctx(ctx), .ctp(ctp),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .acc_idx(acc_idx), .paddr(paddr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: 4 KiB of words, acknowledges one cycle after each request.
    logic [31:0] mem [0:1023];
    logic        clr = 1'b0, ld_en = 1'b0;
    logic [31:0] ld_addr = 32'd0, ld_data = 32'd0;
    int          rd_cnt, wr_cnt;
    logic [31:0] rd_log [0:7];
    logic [31:0] wr_addr_log, wr_data_log;

    always @(posedge clk) begin
        if (!rst_n || clr) begin
            mem_ack <= 1'b0;
            rd_cnt  <= 0;
            wr_cnt  <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    wr_addr_log <= mem_addr;
                    wr_data_log <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                    if (rd_cnt < 8) rd_log[rd_cnt] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
        if (ld_en) mem[ld_addr[11:2]] <= ld_data;
    end

    int tests = 0;
    int fails = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        ld_addr = a; ld_data = d; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Run one walk and leave the bench at the negedge where done is visible.
    task automatic walk(input logic [31:0] va, input logic w, input logic f, input logic s);
        int n;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        vaddr = va; acc_write = w; acc_fetch = f; acc_super = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after start", 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R9 walk timeout: got no done expected done");
        end
    endtask

    typedef struct packed {
        logic [31:0] e0, e1, e2, e3;
        logic        wr, fx, sv;
        logic        xf;
        logic [9:0]  xcode;
        logic [35:0] xpa;
        logic [2:0]  xrd;
        logic        xwr;
        logic [31:0] xwd;
    } vec_t;

    localparam logic [35:0] PA0 = 36'hABCDE0678;
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE002, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, PA0, 3'd4, 1'b1, 32'hABCDE022},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE006, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, PA0, 3'd4, 1'b1, 32'hABCDE066},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE002, 1'b1, 1'b0, 1'b0, 1'b1, 10'h308, 36'd0, 3'd4, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE01A, 1'b0, 1'b0, 1'b0, 1'b1, 10'h30C, 36'd0, 3'd4, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE076, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, PA0, 3'd4, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE00A, 1'b0, 1'b1, 1'b1, 1'b0, 10'h000, PA0, 3'd4, 1'b1, 32'hABCDE02A},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE012, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, PA0, 3'd4, 1'b1, 32'hABCDE032},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE012, 1'b1, 1'b0, 1'b0, 1'b1, 10'h308, 36'd0, 3'd4, 1'b0, 32'd0},
        '{32'h00, 32'h81, 32'hC1, 32'hABCDE002, 1'b0, 1'b0, 1'b0, 1'b1, 10'h004, 36'd0, 3'd1, 1'b0, 32'd0},
        '{32'h02, 32'h81, 32'hC1, 32'hABCDE002, 1'b0, 1'b0, 1'b0, 1'b1, 10'h010, 36'd0, 3'd1, 1'b0, 32'd0},
        '{32'h41, 32'h03, 32'hC1, 32'hABCDE002, 1'b0, 1'b0, 1'b1, 1'b1, 10'h110, 36'd0, 3'd2, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'h00, 32'hABCDE002, 1'b1, 1'b1, 1'b0, 1'b1, 10'h204, 36'd0, 3'd3, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'hC1, 32'h00000001, 1'b0, 1'b0, 1'b0, 1'b1, 10'h310, 36'd0, 3'd4, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'hC1, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1, 10'h304, 36'd0, 3'd4, 1'b0, 32'd0},
        '{32'h41, 32'h02, 32'hC1, 32'hABCDE002, 1'b0, 1'b0, 1'b0, 1'b1, 10'h110, 36'd0, 3'd2, 1'b0, 32'd0},
        '{32'h41, 32'h81, 32'hC1, 32'hABCDE03E, 1'b0, 1'b0, 1'b1, 1'b0, 10'h000, PA0, 3'd4, 1'b0, 32'd0}
    };

    // Global watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R9 watchdog expired: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "busy", 64'(busy), 64'd0);
        chk("R12", "done", 64'(done), 64'd0);
        chk("R12", "mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of vectors at vaddr 0x12345678, ctp 0x10, ctx 2.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            poke(32'h120, v.e0);
            poke(32'h448, v.e1);
            poke(32'h834, v.e2);
            poke(32'hC14, v.e3);
            walk(32'h12345678, v.wr, v.fx, v.sv);
            chk("R3 R4 R6", "fault", 64'(fault), 64'(v.xf));
            chk("R11", "fault_code", 64'(fault_code), 64'(v.xcode));
            chk("R8", "paddr", 64'(paddr), 64'(v.xpa));
            chk("R5", "acc_idx", 64'(acc_idx), 64'({v.wr, v.fx, v.sv}));
            chk("R2", "read count", 64'(rd_cnt), 64'(v.xrd));
            chk("R7", "write count", 64'(wr_cnt), 64'(v.xwr));
            if (v.xwr) begin
                chk("R7", "write data", 64'(wr_data_log), 64'(v.xwd));
                chk("R7", "write addr", 64'(wr_addr_log), 64'h0C14);
            end
            if (i == 0) begin
                chk("R1", "context fetch", 64'(rd_log[0]), 64'h120);
                chk("R2", "level1 fetch", 64'(rd_log[1]), 64'h448);
                chk("R2", "level2 fetch", 64'(rd_log[2]), 64'h834);
                chk("R2", "level3 fetch", 64'(rd_log[3]), 64'hC14);
                // R9: done is a pulse and results hold afterwards
                repeat (4) @(negedge clk);
                chk("R9", "done dropped", 64'(done), 64'd0);
                chk("R9", "paddr held", 64'(paddr), 64'(PA0));
                chk("R9", "idle", 64'(busy), 64'd0);
            end
        end

        // Other index slices: vaddr 0x03FFF123, ctx 5 (context entry 0x150).
        ctx = 8'd5;
        poke(32'h150, 32'h41);
        poke(32'h40C, 32'h81);
        poke(32'h8FC, 32'hC1);
        poke(32'hCFC, 32'h12345002);
        walk(32'h03FFF123, 1'b0, 1'b0, 1'b1);
        chk("R1", "context fetch ctx5", 64'(rd_log[0]), 64'h150);
        chk("R2", "level1 slice", 64'(rd_log[1]), 64'h40C);
        chk("R2", "level2 slice", 64'(rd_log[2]), 64'h8FC);
        chk("R2", "level3 slice", 64'(rd_log[3]), 64'hCFC);
        chk("R8", "paddr slice", 64'(paddr), 64'h123450123);
        chk("R7", "referenced write-back", 64'(wr_data_log), 64'h12345022);
        ctx = 8'd2;

        // R9: a start while busy is ignored.
        poke(32'h120, 32'h41);
        poke(32'h448, 32'h81);
        poke(32'h834, 32'hC1);
        poke(32'hC14, 32'hABCDE022);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        vaddr = 32'h12345678; acc_write = 1'b0; acc_fetch = 1'b0; acc_super = 1'b0;
        start = 1'b1;
        @(negedge clk);
        vaddr = 32'h0; acc_write = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 200 && !done; n++) @(negedge clk);
        chk("R9", "busy start ignored code", 64'(fault_code), 64'd0);
        chk("R9", "busy start ignored paddr", 64'(paddr), 64'(PA0));
        chk("R9", "busy start ignored acc", 64'(acc_idx), 64'd0);
        chk("R9", "busy start ignored reads", 64'(rd_cnt), 64'd4);
        chk("R7", "no write when flags set", 64'(wr_cnt), 64'd0);
        repeat (3) @(negedge clk);
        chk("R10", "quiet when idle", 64'(mem_req), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule